// File: doc/BRIEF.md
# Guarded Single-Precision Less-or-Equal Compare Unit

This block is a one-cycle execution unit that tests whether operand A is less than or equal to operand B. Both operands are IEEE-754 single-precision values, and the unit returns the answer as an integer 0 or 1. An issue strobe starts an operation, which carries a destination tag and a guard word. Only the lowest bit of the guard counts. When that bit is clear, the operation neither writes a result nor touches the exception flags.

Before the compare, a subnormal operand is replaced by zero. Both zero encodings compare as equal. If either operand is a NaN, the result is 0. The unit holds a two-bit sticky exception-flag register:

- **INV** records an invalid (NaN) compare.
- **IFZ** records a flushed subnormal input.

Other execution units that finish in the same cycle can OR their own flag updates into this register. A software status write replaces the register's contents, and it takes priority over every update that arrives in the same cycle.

Top module: `fle_cmp_unit`

## Requirements
- R1: After a guarded-true issue, `res_data` is 1 when A <= B numerically and 0 otherwise. Bits 31..1 of `res_data` are always 0.
- R2: +0 (0x00000000) and -0 (0x80000000) compare as equal, so either order gives 1.
- R3: An operand with exponent field 0 and a nonzero fraction is treated as zero for the compare. Such an operand sets IFZ, which is bit 1 of the flag word.
- R4: If either operand has exponent field 0xFF and a nonzero fraction, the result is 0 and INV is set. INV is bit 0 of the flag word.
- R5: +INF <= -INF gives 0. +INF <= +INF gives 1. -INF <= any non-NaN value gives 1.
- R6: Only `guard[0]` is significant. An issue with `guard[0]`=0 leaves `res_we` low and changes neither flag.
- R7: The result appears exactly one cycle after issue, with `res_we` high and `res_tag` equal to the issued `dst_tag`. The compare's flag contribution becomes visible at that same edge.
- R8: Without a software write, a flag that is set stays set.
- R9: Each flag becomes the OR of its old value, the compare's contribution and all bits of the matching `ext_*` vector presented in that cycle.
- R10: A software write (`sw_wr`) loads `sw_wdata` into the flags at the next edge. This ignores any compare or external update in the same cycle.
- R11: After reset, `res_we`, `flag_inv` and `flag_ifz` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | Operation issued this cycle |
| guard | input | GUARD_W (32) | Guard word; bit 0 enables the operation |
| src_a | input | DATA_W (32) | Operand A, single-precision |
| src_b | input | DATA_W (32) | Operand B, single-precision |
| dst_tag | input | TAG_W (6) | Destination tag of the operation |
| ext_inv | input | N_EXT (2) | INV updates from other units, one bit per unit |
| ext_ifz | input | N_EXT (2) | IFZ updates from other units, one bit per unit |
| sw_wr | input | 1 | Software write of the flag word |
| sw_wdata | input | 2 | New flag word: bit 0 is INV, bit 1 is IFZ |
| res_we | output | 1 | Result write enable |
| res_tag | output | TAG_W (6) | Tag of the written result |
| res_data | output | DATA_W (32) | Integer result, 0 or 1 |
| flag_inv | output | 1 | Sticky invalid flag |
| flag_ifz | output | 1 | Sticky flushed-input flag |

## Verification
In a single cycle, three things can all target the flag register:

- a guarded compare,
- external flag updates from other units,
- a software write.

The bench sweeps every pair from a set of sixteen boundary encodings, with the guard both true and false. For each pair it computes a pattern of external flag bits and, on some pairs, overlaps a software write with the compare. After each edge, the flag word is judged against a bench model. In that model the software write replaces the flags outright. Otherwise, the old flags, the compare's own flags (computed from a signed-magnitude ordering key) and the external bits are ORed together.

// File: rtl/fle_pkg.sv
package fle_pkg;
   // Flag word layout: bit 0 invalid, bit 1 flushed input
   typedef struct packed {
      logic ifz;
      logic inv;
   } fle_flags_t;

   localparam int FLAG_W = 2;
endpackage

// File: rtl/fle_operand_prep.sv
module fle_operand_prep #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int DATA_W = 1 + EXP_W + MAN_W
) (
   input  logic [DATA_W-1:0] op_in,
   output logic [DATA_W-1:0] op_out,
   output logic              is_nan,
   output logic              is_sub
);
   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   assign exp_f = op_in[DATA_W-2 -: EXP_W];
   assign man_f = op_in[MAN_W-1:0];

   always_comb begin
      is_nan = (&exp_f) && (|man_f);
      is_sub = (~|exp_f) && (|man_f);
      op_out = is_sub ? {op_in[DATA_W-1], {(DATA_W-1){1'b0}}} : op_in;
   end
endmodule

// File: rtl/fle_order_core.sv
module fle_order_core #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              any_nan,
   output logic              le
);
   logic [DATA_W-2:0] mag_a, mag_b;
   logic              sa, sb;

   assign mag_a = a[DATA_W-2:0];
   assign mag_b = b[DATA_W-2:0];
   assign sa    = a[DATA_W-1];
   assign sb    = b[DATA_W-1];

   always_comb begin
      if (any_nan)
         le = 1'b0;
      else if ((~|mag_a) && (~|mag_b))
         le = 1'b1;
      else if (sa != sb)
         le = sa;
      else if (!sa)
         le = (mag_a <= mag_b);
      else
         le = (mag_a >= mag_b);
   end
endmodule

// File: rtl/fle_sticky_flags.sv
module fle_sticky_flags
   import fle_pkg::*;
#(
   parameter int N_EXT = 2,
   localparam int EXT_W = (N_EXT > 0) ? N_EXT : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_vld,
   input  fle_flags_t       cmp_upd,
   input  logic [EXT_W-1:0] ext_inv,
   input  logic [EXT_W-1:0] ext_ifz,
   input  logic             sw_wr,
   input  fle_flags_t       sw_wdata,
   output fle_flags_t       flags_q
);
   fle_flags_t ext_or;
   fle_flags_t cmp_or;

   generate
      if (N_EXT > 0) begin : g_ext
         assign ext_or = '{ifz: |ext_ifz, inv: |ext_inv};
      end else begin : g_no_ext
         assign ext_or = '0;
      end
   endgenerate

   assign cmp_or = cmp_vld ? cmp_upd : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)
         flags_q <= '0;
      else if (sw_wr)
         flags_q <= sw_wdata;
      else
         flags_q <= flags_q | cmp_or | ext_or;
   end

   // R8
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
   // R10
   sw_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_wr |=> (flags_q == $past(sw_wdata)));
   // R9
   ext_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_wr && (|ext_inv)) |=> flags_q.inv);
endmodule

// File: rtl/fle_cmp_unit.sv
module fle_cmp_unit
   import fle_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int MAN_W   = 23,
   parameter int DATA_W  = 32,
   parameter int GUARD_W = 32,
   parameter int TAG_W   = 6,
   parameter int N_EXT   = 2,
   localparam int EXT_W  = (N_EXT > 0) ? N_EXT : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue_vld,
   input  logic [GUARD_W-1:0] guard,
   input  logic [DATA_W-1:0]  src_a,
   input  logic [DATA_W-1:0]  src_b,
   input  logic [TAG_W-1:0]   dst_tag,
   input  logic [EXT_W-1:0]   ext_inv,
   input  logic [EXT_W-1:0]   ext_ifz,
   input  logic               sw_wr,
   input  logic [1:0]         sw_wdata,
   output logic               res_we,
   output logic [TAG_W-1:0]   res_tag,
   output logic [DATA_W-1:0]  res_data,
   output logic               flag_inv,
   output logic               flag_ifz
);
   generate
      if (DATA_W != 1 + EXP_W + MAN_W) begin : g_bad_width
         initial $fatal(1, "DATA_W must equal 1 + EXP_W + MAN_W");
      end
      if (GUARD_W < 1 || TAG_W < 1 || EXP_W < 2 || MAN_W < 1) begin : g_bad_param
         initial $fatal(1, "GUARD_W, TAG_W, MAN_W must be >= 1 and EXP_W >= 2");
      end
   endgenerate

   logic [DATA_W-1:0] ops_raw  [2];
   logic [DATA_W-1:0] ops_flat [2];
   logic [1:0]        nan_v, sub_v;

   assign ops_raw[0] = src_a;
   assign ops_raw[1] = src_b;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_prep
         fle_operand_prep #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_prep (
            .op_in  (ops_raw[i]),
            .op_out (ops_flat[i]),
            .is_nan (nan_v[i]),
            .is_sub (sub_v[i])
         );
      end
   endgenerate

   logic le;
   fle_order_core #(.DATA_W(DATA_W)) u_core (
      .a       (ops_flat[0]),
      .b       (ops_flat[1]),
      .any_nan (|nan_v),
      .le      (le)
   );

   logic       fire;
   fle_flags_t cmp_upd;
   fle_flags_t flags_q;

   assign fire    = issue_vld & guard[0];
   assign cmp_upd = '{ifz: |sub_v, inv: |nan_v};

   fle_sticky_flags #(.N_EXT(N_EXT)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_vld  (fire),
      .cmp_upd  (cmp_upd),
      .ext_inv  (ext_inv),
      .ext_ifz  (ext_ifz),
      .sw_wr    (sw_wr),
      .sw_wdata (fle_flags_t'(sw_wdata)),
      .flags_q  (flags_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_we   <= 1'b0;
         res_tag  <= '0;
         res_data <= '0;
      end else begin
         res_we <= fire;
         if (fire) begin
            res_tag  <= dst_tag;
            res_data <= {{(DATA_W-1){1'b0}}, le};
         end
      end
   end

   assign flag_inv = flags_q.inv;
   assign flag_ifz = flags_q.ifz;

   // R6
   guard_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && !guard[0]) |=> !res_we);
   // R7
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && guard[0]) |=> (res_we && res_tag == $past(dst_tag)));
   // R1
   result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_we |-> (res_data[DATA_W-1:1] == '0));
   // R4
   nan_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_vld && guard[0] && (|nan_v) && !sw_wr) |=> (res_data[0] == 1'b0 && flag_inv));
endmodule

// File: tb/fle_cmp_unit_bench.sv
module fle_cmp_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        issue_vld;
   logic [31:0] guard;
   logic [31:0] src_a, src_b;
   logic [5:0]  dst_tag;
   logic [1:0]  ext_inv, ext_ifz;
   logic        sw_wr;
   logic [1:0]  sw_wdata;
   logic        res_we;
   logic [5:0]  res_tag;
   logic [31:0] res_data;
   logic        flag_inv, flag_ifz;

   int n_chk = 0;
   int n_err = 0;
   logic [1:0] model_flags;

   always #4 clk = ~clk;

   fle_cmp_unit u_fle_cmp_unit (
      .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .guard(guard),
      .src_a(src_a), .src_b(src_b), .dst_tag(dst_tag),
      .ext_inv(ext_inv), .ext_ifz(ext_ifz), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
      .res_we(res_we), .res_tag(res_tag), .res_data(res_data),
      .flag_inv(flag_inv), .flag_ifz(flag_ifz)
   );

   function automatic logic [31:0] pick(input int k);
      case (k)
         0: pick = 32'h0000_0000;  1: pick = 32'h8000_0000;
         2: pick = 32'h0040_0000;  3: pick = 32'h8000_0001;
         4: pick = 32'h3f80_0000;  5: pick = 32'hbf80_0000;
         6: pick = 32'h4040_0000;  7: pick = 32'hc020_0000;
         8: pick = 32'h7f80_0000;  9: pick = 32'hff80_0000;
         10: pick = 32'hffff_ffff; 11: pick = 32'h7fc0_0000;
         12: pick = 32'h7f80_0001; 13: pick = 32'h0080_0000;
         14: pick = 32'h7f7f_ffff; default: pick = 32'h3f80_0001;
      endcase
   endfunction

   function automatic bit is_nan(input logic [31:0] v);
      return v[30:23] == 8'hff && v[22:0] != 0;
   endfunction
   function automatic bit is_sub(input logic [31:0] v);
      return v[30:23] == 8'h00 && v[22:0] != 0;
   endfunction
   // signed ordering key; subnormals and both zeros map to 0
   function automatic longint key(input logic [31:0] v);
      longint m;
      m = is_sub(v) ? 0 : longint'(v[30:0]);
      return v[31] ? -m : m;
   endfunction

   function automatic string req_of(input logic [31:0] a, input logic [31:0] b);
      if (is_nan(a) || is_nan(b)) return "R4";
      if (is_sub(a) || is_sub(b)) return "R3";
      if (a[30:0] == 31'h7f800000 || b[30:0] == 31'h7f800000) return "R5";
      if (a[30:0] == 0 && b[30:0] == 0) return "R2";
      return "R1";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive at negedge, sample one negedge later (after the capturing edge)
   task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] g,
                     input logic [5:0] tag, input logic [1:0] einv, input logic [1:0] eifz,
                     input bit sw, input logic [1:0] swd, input bit iss);
      bit fire, exp_le;
      logic [1:0] cmpf;
      issue_vld = iss; guard = g; src_a = a; src_b = b; dst_tag = tag;
      ext_inv = einv; ext_ifz = eifz; sw_wr = sw; sw_wdata = swd;
      fire   = iss && g[0];
      exp_le = !(is_nan(a) || is_nan(b)) && (key(a) <= key(b));
      cmpf   = {is_sub(a) || is_sub(b), is_nan(a) || is_nan(b)};
      if (sw) model_flags = swd;
      else model_flags = model_flags | (fire ? cmpf : 2'b00) | {|eifz, |einv};
      @(negedge clk);
      check(res_we == fire, fire ? "R7" : "R6", "res_we", res_we, fire);
      if (fire) begin
         check(res_data == {31'b0, exp_le}, req_of(a, b), "res_data", res_data, exp_le);
         check(res_tag == tag, "R7", "res_tag", res_tag, tag);
      end
      check({flag_ifz, flag_inv} == model_flags,
            sw ? "R10" : ((einv | eifz) != 0 ? "R9" : (fire ? req_of(a, b) : "R6")),
            "flags", {flag_ifz, flag_inv}, model_flags);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      rst_n = 1'b0; issue_vld = 0; guard = 0; src_a = 0; src_b = 0; dst_tag = 0;
      ext_inv = 0; ext_ifz = 0; sw_wr = 0; sw_wdata = 0;
      model_flags = 2'b00;
      repeat (3) @(negedge clk);
      // R11
      check(res_we == 0 && flag_inv == 0 && flag_ifz == 0, "R11", "reset state",
            {res_we, flag_ifz, flag_inv}, 0);
      rst_n = 1'b1;

      // full pair sweep, guard true and false
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            for (int g = 0; g < 2; g++) begin
               logic [1:0] ei, ez;
               bit sw;
               ei = ((i + j) % 5 == 0) ? 2'b10 : 2'b00;
               ez = ((i * j) % 7 == 3) ? 2'b01 : 2'b00;
               sw = ((i + j + g) % 11 == 0);
               op(0, 0, 0, 0, 0, 0, 1'b1, 2'b00, 1'b0);           // R10 clear
               op(pick(i), pick(j), g ? 32'h0000_0003 : 32'hffff_fffe,
                  6'(i * 16 + j + g), ei, ez, sw, 2'(i), 1'b1);
            end
         end
      end

      // R8 sticky: raise INV, then clean ops keep it
      op(0, 0, 0, 0, 0, 0, 1'b1, 2'b00, 1'b0);
      op(32'hffff_ffff, 32'h3f80_0000, 32'h1, 6'd1, 0, 0, 0, 0, 1'b1);
      op(32'h3f80_0000, 32'h4040_0000, 32'h1, 6'd2, 0, 0, 0, 0, 1'b1);
      op(32'h3f80_0000, 32'h0040_0000, 32'h1, 6'd3, 0, 0, 0, 0, 1'b1);
      op(0, 0, 0, 0, 0, 0, 0, 0, 1'b0);                          // idle
      check({flag_ifz, flag_inv} == 2'b11, "R8", "sticky after idle",
            {flag_ifz, flag_inv}, 2'b11);
      // R10 software write clears despite colliding NaN compare and ext bits
      op(32'h7fc0_0000, 32'h0040_0000, 32'h1, 6'd4, 2'b11, 2'b11, 1'b1, 2'b00, 1'b1);
      check({flag_ifz, flag_inv} == 2'b00, "R10", "write wins",
            {flag_ifz, flag_inv}, 2'b00);
      // R9 external only, no issue
      op(0, 0, 0, 0, 2'b01, 2'b00, 0, 0, 1'b0);
      op(0, 0, 0, 0, 2'b00, 2'b10, 0, 0, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule